// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming frame is addressed to this station. It watches the serial receive stream while reception is active and takes the first 48 data bits, which form the destination address. Bits arrive least significant bit of each byte first. After the 48th bit it emits a one-cycle decision strobe, together with an accept flag and a flag giving the address type.

An address whose first bit is 0 is a physical address. It is accepted when it equals the configured station address. A group mode can exclude the last four received bits from that comparison, so that sixteen neighbouring stations share one filter. An address whose first bit is 1 is a multicast or broadcast address. With hashing off, such an address is accepted or rejected wholesale by a mode bit. With hashing on, a CRC-32 is run over the 48 address bits, and six bits of the CRC select one bit of a 64-bit filter vector.

The configuration inputs (station address, filter vector, mode bits) come from registers held elsewhere. They are expected to stay constant during a reception. Dropping `rx_active_i` ends a reception and re-arms the block for the next frame.

Top module: `rx_addr_filter`

## Requirements
- R1: An address bit is taken on a rising clock edge where `rx_active_i` and `bit_valid_i` are both 1. Idle cycles between bits are allowed. The i-th bit taken (i counting from 0) is compared with `station_addr_i[i]`, so byte k bit j of the address is serial index 8k+j.
- R2: `decision_valid_o` is high for exactly one cycle, the cycle right after the edge that takes the 48th bit. Bits presented after the 48th are ignored until `rx_active_i` falls, so a reception gives at most one strobe.
- R3: If `rx_active_i` falls before 48 bits are taken, no strobe is given. The next reception starts again at serial index 0.
- R4: During the strobe, `addr_mcast_o` equals the first address bit. `accept_o` and `addr_mcast_o` hold their value between strobes.
- R5: For a physical address (first bit 0) with group mode off, `accept_o` is 1 exactly when all 48 bits equal `station_addr_i`.
- R6: With `group_mode_i` set, serial indices 44 to 47 are left out of the physical comparison. Indices 0 to 43 must still match.
- R7: For a multicast address (first bit 1) with `hash_en_i` clear, `accept_o` equals `accept_all_mcast_i`.
- R8: With `hash_en_i` set, a CRC-32 with polynomial 0x04C11DB7 is preset to all ones. For each bit d, in arrival order, the CRC steps as: feedback = crc[31]^d, crc = crc<<1, then crc ^= 0x04C11DB7 when feedback is 1. The 6-bit index is crc[5:0] after the 48th bit, taken without inversion.
- R9: The hash index picks filter bit `mcast_filter_i[8*B+b]`, where B = {crc[0],crc[1],crc[2]} and b = {crc[3],crc[4],crc[5]}, each written MSB first. The frame is accepted when that bit is 1. With `hash_en_i` set, `accept_all_mcast_i` has no effect.
- R10: While `rst_ni` is low, `decision_valid_o`, `accept_o` and `addr_mcast_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_active_i | input | 1 | High for the duration of a reception; low re-arms the filter |
| bit_valid_i | input | 1 | `bit_i` carries a received bit this cycle |
| bit_i | input | 1 | Received serial data bit |
| station_addr_i | input | 48 | Station address, bit i compared with the i-th received bit |
| mcast_filter_i | input | 64 | Multicast hash filter vector |
| group_mode_i | input | 1 | Exclude the last 4 address bits from the station match |
| accept_all_mcast_i | input | 1 | Accept every multicast address when hashing is off |
| hash_en_i | input | 1 | Filter multicast addresses through the CRC hash |
| decision_valid_o | output | 1 | One-cycle strobe after the 48th address bit |
| accept_o | output | 1 | Accept decision, valid with the strobe and held after it |
| addr_mcast_o | output | 1 | First address bit (1 = multicast/broadcast), held like `accept_o` |

## Verification
The assertions assume that the station address, filter and mode inputs do not change between the first bit of a reception and the cycle after the decision strobe. The checker compares the strobe cycle against the configuration present on that cycle. The bench changes configuration only while `rx_active_i` is low and at least two cycles after the last bit. It varies bit spacing, truncates receptions, and sends surplus bits after the 48th. Hash cases build the filter from an index computed in the bench, so that exactly the addressed bit is set, or exactly that bit is cleared.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int unsigned ADDR_BITS_DEF   = 48;
  localparam int unsigned CRC_W_DEF       = 32;
  localparam logic [31:0] CRC_POLY_DEF    = 32'h04C1_1DB7;
  localparam int unsigned HASH_BITS_DEF   = 6;
  localparam int unsigned GROUP_MASK_DEF  = 4;

  typedef struct packed {
    logic take;
    logic first;
    logic last;
  } bit_evt_t;
endpackage

// File: rtl/addr_bit_counter.sv
module addr_bit_counter
  import addr_filt_pkg::*;
#(
  parameter int unsigned ADDR_BITS = ADDR_BITS_DEF,
  parameter int unsigned IDX_W     = $clog2(ADDR_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             bit_valid_i,
  output bit_evt_t         evt_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] DONE_CNT = IDX_W'(ADDR_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BITS - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             take;

  assign take        = active_i && bit_valid_i && (cnt_q != DONE_CNT);
  assign evt_o.take  = take;
  assign evt_o.first = take && (cnt_q == '0);
  assign evt_o.last  = take && (cnt_q == LAST_IDX);
  assign idx_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (take)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/addr_crc_hash.sv
module addr_crc_hash
  import addr_filt_pkg::*;
#(
  parameter int unsigned     CRC_W     = CRC_W_DEF,
  parameter logic [CRC_W-1:0] CRC_POLY = CRC_POLY_DEF,
  parameter int unsigned     HASH_BITS = HASH_BITS_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 take_i,
  input  logic                 bit_i,
  output logic [HASH_BITS-1:0] hash_idx_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_step;
  logic             fb;

  // data enters at bit 0 via the polynomial's constant term
  assign fb       = crc_q[CRC_W-1] ^ bit_i;
  assign crc_step = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  // index reflects the register including the bit being taken now
  assign hash_idx_o = crc_step[HASH_BITS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (clear_i) crc_q <= '1;
    else if (take_i)  crc_q <= crc_step;
  end
endmodule

// File: rtl/station_compare.sv
module station_compare
  import addr_filt_pkg::*;
#(
  parameter int unsigned ADDR_BITS  = ADDR_BITS_DEF,
  parameter int unsigned GROUP_MASK = GROUP_MASK_DEF,
  parameter int unsigned IDX_W      = $clog2(ADDR_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 take_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 bit_i,
  input  logic [ADDR_BITS-1:0] station_addr_i,
  input  logic                 group_mode_i,
  output logic                 match_o
);
  localparam logic [IDX_W-1:0] MASK_START = IDX_W'(ADDR_BITS - GROUP_MASK);

  logic miss_q;
  logic cur_miss;
  logic masked;

  assign masked   = group_mode_i && (idx_i >= MASK_START);
  assign cur_miss = take_i && !masked && (bit_i != station_addr_i[idx_i]);
  assign match_o  = !(miss_q || cur_miss);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       miss_q <= 1'b0;
    else if (clear_i)  miss_q <= 1'b0;
    else if (cur_miss) miss_q <= 1'b1;
  end
endmodule

// File: rtl/hash_filter_lookup.sv
module hash_filter_lookup
  import addr_filt_pkg::*;
#(
  parameter int unsigned HASH_BITS = HASH_BITS_DEF,
  parameter int unsigned FILT_W    = 1 << HASH_BITS
) (
  input  logic [HASH_BITS-1:0] idx_i,
  input  logic [FILT_W-1:0]    filter_i,
  output logic                 hit_o
);
  localparam int unsigned SEL_W = HASH_BITS / 2;

  logic [SEL_W-1:0]     byte_sel;
  logic [SEL_W-1:0]     bit_sel;
  logic [HASH_BITS-1:0] pos;

  // low index bits pick the byte, high bits the bit; each field MSB-first
  for (genvar g = 0; g < SEL_W; g++) begin : g_rev
    assign byte_sel[g] = idx_i[SEL_W-1-g];
    assign bit_sel[g]  = idx_i[HASH_BITS-1-g];
  end

  assign pos   = {byte_sel, bit_sel};
  assign hit_o = filter_i[pos];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int unsigned      ADDR_BITS  = ADDR_BITS_DEF,
  parameter int unsigned      CRC_W      = CRC_W_DEF,
  parameter logic [CRC_W-1:0] CRC_POLY   = CRC_POLY_DEF,
  parameter int unsigned      HASH_BITS  = HASH_BITS_DEF,
  parameter int unsigned      GROUP_MASK = GROUP_MASK_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rx_active_i,
  input  logic                        bit_valid_i,
  input  logic                        bit_i,
  input  logic [ADDR_BITS-1:0]        station_addr_i,
  input  logic [(1<<HASH_BITS)-1:0]   mcast_filter_i,
  input  logic                        group_mode_i,
  input  logic                        accept_all_mcast_i,
  input  logic                        hash_en_i,
  output logic                        decision_valid_o,
  output logic                        accept_o,
  output logic                        addr_mcast_o
);
  localparam int unsigned IDX_W  = $clog2(ADDR_BITS + 1);
  localparam int unsigned FILT_W = 1 << HASH_BITS;

  bit_evt_t             evt;
  logic [IDX_W-1:0]     idx;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 st_match;
  logic                 hash_hit;
  logic                 clear;
  logic                 mcast_q;
  logic                 mcast_now;
  logic                 decide;

  assign clear = !rx_active_i;

  addr_bit_counter #(.ADDR_BITS(ADDR_BITS), .IDX_W(IDX_W)) u_cnt (
    .clk_i, .rst_ni,
    .active_i    (rx_active_i),
    .bit_valid_i (bit_valid_i),
    .evt_o       (evt),
    .idx_o       (idx)
  );

  addr_crc_hash #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .HASH_BITS(HASH_BITS)) u_crc (
    .clk_i, .rst_ni,
    .clear_i    (clear),
    .take_i     (evt.take),
    .bit_i      (bit_i),
    .hash_idx_o (hash_idx)
  );

  station_compare #(.ADDR_BITS(ADDR_BITS), .GROUP_MASK(GROUP_MASK), .IDX_W(IDX_W)) u_cmp (
    .clk_i, .rst_ni,
    .clear_i        (clear),
    .take_i         (evt.take),
    .idx_i          (idx),
    .bit_i          (bit_i),
    .station_addr_i (station_addr_i),
    .group_mode_i   (group_mode_i),
    .match_o        (st_match)
  );

  hash_filter_lookup #(.HASH_BITS(HASH_BITS), .FILT_W(FILT_W)) u_lut (
    .idx_i    (hash_idx),
    .filter_i (mcast_filter_i),
    .hit_o    (hash_hit)
  );

  assign mcast_now = evt.first ? bit_i : mcast_q;

  always_comb begin
    if (!mcast_now)     decide = st_match;
    else if (hash_en_i) decide = hash_hit;
    else                decide = accept_all_mcast_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mcast_q <= 1'b0;
    else if (evt.first) mcast_q <= bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
      addr_mcast_o     <= 1'b0;
    end else begin
      decision_valid_o <= evt.last;
      if (evt.last) begin
        accept_o     <= decide;
        addr_mcast_o <= mcast_now;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int unsigned ADDR_BITS  = 48,
  parameter int unsigned GROUP_MASK = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_active_i,
  input logic                 bit_valid_i,
  input logic                 bit_i,
  input logic [ADDR_BITS-1:0] station_addr_i,
  input logic                 group_mode_i,
  input logic                 accept_all_mcast_i,
  input logic                 hash_en_i,
  input logic                 decision_valid_o,
  input logic                 accept_o,
  input logic                 addr_mcast_o
);
  localparam int unsigned KEEP = ADDR_BITS - GROUP_MASK;

  int unsigned          seen;
  logic [ADDR_BITS-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen  <= 0;
      shreg <= '0;
    end else if (!rx_active_i) begin
      seen <= 0;
    end else if (bit_valid_i && seen < ADDR_BITS) begin
      shreg[seen] <= bit_i;
      seen        <= seen + 1;
    end
  end

  // R2
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o);

  // R2
  valid_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> (seen == ADDR_BITS) && $past(rx_active_i && bit_valid_i));

  // R3
  idle_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_active_i |=> !decision_valid_o);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> $stable(accept_o) && $stable(addr_mcast_o));

  // R4
  type_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> addr_mcast_o == shreg[0]);

  // R5
  phys_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o && !addr_mcast_o && !group_mode_i |-> accept_o == (shreg == station_addr_i));

  // R6
  group_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o && !addr_mcast_o && group_mode_i
      |-> accept_o == (shreg[KEEP-1:0] == station_addr_i[KEEP-1:0]));

  // R7
  mcast_nohash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o && addr_mcast_o && !hash_en_i |-> accept_o == accept_all_mcast_i);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.ADDR_BITS(ADDR_BITS), .GROUP_MASK(GROUP_MASK)) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .rx_active_i        (rx_active_i),
  .bit_valid_i        (bit_valid_i),
  .bit_i              (bit_i),
  .station_addr_i     (station_addr_i),
  .group_mode_i       (group_mode_i),
  .accept_all_mcast_i (accept_all_mcast_i),
  .hash_en_i          (hash_en_i),
  .decision_valid_o   (decision_valid_o),
  .accept_o           (accept_o),
  .addr_mcast_o       (addr_mcast_o)
);

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_active_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0;
  logic [47:0] station = '0;
  logic [63:0] filt = '0;
  logic        grp = 1'b0, all_mc = 1'b0, hash_en = 1'b0;
  logic        dv, acc, mc;

  int errors = 0, checks = 0;
  int pulses = 0;
  logic last_acc = 1'b0, last_mc = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk_i(clk), .rst_ni(rst_ni), .rx_active_i(rx_active_i), .bit_valid_i(bit_valid_i),
    .bit_i(bit_i), .station_addr_i(station), .mcast_filter_i(filt), .group_mode_i(grp),
    .accept_all_mcast_i(all_mc), .hash_en_i(hash_en), .decision_valid_o(dv),
    .accept_o(acc), .addr_mcast_o(mc));

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic f = c[31] ^ a[i];
      c = c << 1;
      if (f) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  function automatic int ref_pos(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    int byte_n = c[0] * 4 + c[1] * 2 + c[2];
    int bit_n  = c[3] * 4 + c[4] * 2 + c[5];
    return byte_n * 8 + bit_n;
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    if (!a[0]) begin
      if (grp) return a[43:0] == station[43:0];
      return a == station;
    end
    if (hash_en) return filt[ref_pos(a)];
    return all_mc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: a bit count and the collected address
  int          m_cnt = 0;
  logic [47:0] m_addr = '0;
  logic        e_v = 1'b0, e_a = 1'b0, e_m = 1'b0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt = 0; e_v = 0; e_a = 0; e_m = 0;
    end else begin
      e_v = 1'b0;
      if (!rx_active_i) m_cnt = 0;
      else if (bit_valid_i && m_cnt < 48) begin
        m_addr[m_cnt] = bit_i;
        m_cnt++;
        if (m_cnt == 48) begin
          e_v = 1'b1;
          e_a = ref_accept(m_addr);
          e_m = m_addr[0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      chk(dv == 0 && acc == 0 && mc == 0, "R10 outputs in reset", {dv, acc, mc}, 0);
    end else if (!done) begin
      chk(dv == e_v, "R2 decision_valid_o per cycle", dv, e_v);
      chk(acc == e_a, "R5/R7/R8 accept_o per cycle", acc, e_a);
      chk(mc == e_m, "R4 addr_mcast_o per cycle", mc, e_m);
      if (dv) begin
        pulses++;
        last_acc = acc;
        last_mc  = mc;
      end
    end
  end

  task automatic send(input logic [47:0] a, input int nbits, input int gap);
    pulses = 0;
    @(negedge clk);
    rx_active_i = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      bit_valid_i = 1'b1;
      bit_i = (i < 48) ? a[i] : 1'b1;
      @(negedge clk);
      bit_valid_i = 1'b0;
      bit_i = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    rx_active_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [47:0] a, input logic exp_acc, input string req);
    send(a, 48, 0);
    chk(pulses == 1, {req, " one strobe"}, pulses, 1);
    chk(last_acc == exp_acc, {req, " accept"}, last_acc, exp_acc);
    chk(last_mc == a[0], {req, " R4 type bit"}, last_mc, a[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] h1, h2;
    station = 48'hA1B2_C3D4_E5F6;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 exact and mismatching physical addresses
    frame(station, 1'b1, "R5 exact match");
    frame(station ^ (48'd1 << 47), 1'b0, "R5 last bit differs");
    frame(station ^ 48'd2, 1'b0, "R5 second bit differs");
    // R6 group mode masks indices 44..47 only
    grp = 1'b1;
    frame(station ^ (48'd1 << 47), 1'b1, "R6 masked bit 47");
    frame(station ^ (48'd1 << 44), 1'b1, "R6 masked bit 44");
    frame(station ^ (48'd1 << 43), 1'b0, "R6 bit 43 still compared");
    grp = 1'b0;

    // R1 spaced bits
    send(station, 48, 2);
    chk(pulses == 1 && last_acc == 1'b1, "R1 gapped bits accept", {pulses[7:0], last_acc}, {8'd1, 1'b1});

    // R3 truncated reception, then a full one restarts at index 0
    send(station, 20, 0);
    chk(pulses == 0, "R3 truncated gives no strobe", pulses, 0);
    frame(station, 1'b1, "R3 restart after truncation");

    // R2 surplus bits after the 48th
    send(station, 60, 0);
    chk(pulses == 1, "R2 surplus bits one strobe", pulses, 1);
    chk(last_acc == 1'b1, "R2 surplus bits ignored", last_acc, 1);

    // R7 multicast without hashing
    all_mc = 1'b1;
    frame(48'hFFFF_FFFF_FFFF, 1'b1, "R7 broadcast accept_all");
    frame(48'h0000_5E00_0001, 1'b1, "R7 multicast accept_all");
    all_mc = 1'b0;
    frame(48'h0000_5E00_0001, 1'b0, "R7 multicast rejected");

    // R8 R9 hash filtering
    h1 = 48'h0000_5E00_0001;
    h2 = 48'h3412_00AB_CD01;
    hash_en = 1'b1;
    filt = 64'd1 << ref_pos(h1);
    frame(h1, 1'b1, "R8 hash selected bit set");
    filt = ~(64'd1 << ref_pos(h1));
    frame(h1, 1'b0, "R9 hash selected bit clear");
    filt = 64'd1 << ref_pos(h2);
    frame(h2, 1'b1, "R8 second hash address");
    all_mc = 1'b1;
    filt = '0;
    frame(h2, 1'b0, "R9 accept_all ignored under hash");
    frame(station, 1'b1, "R5 physical unaffected by hash");
    hash_en = 1'b0;
    all_mc = 1'b0;

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule